// File: doc/BRIEF.md
# Mixed-Aspect Dual-Port Block RAM

This block is a true dual-port synchronous RAM over one fixed 18 Kib store. The store holds 16384 data bits and 2048 parity bits. Each of the two ports has its own clock and its own parameter-chosen word shape. One port can therefore write narrow words while the other reads wide words over the same bits. For example, one side can run a byte-plus-parity stream while the other side sees four such bytes per word. The two ports must agree on parity: both use a parity shape or neither does, and a mixed choice stops elaboration with an error.

Both ports sample their address, write data and write enable on their own rising clock edge. Each port reads in read-before-write order and returns data one edge after the address. A per-port option adds a second output register. When both ports write overlapping linear bits in the same cycle, a collision flag goes high on the port-A clock for one cycle. The stored value in that case is left undefined.

Top module: `mab_dpram`

## Requirements
- R1: A port of data width D (1, 2, 4, 8, 16 or 32 data bits) maps word address a to linear data bits a*D up to a*D+D-1. Parity shapes carry P = D/8 parity bits, and word a maps to parity bits a*P up to a*P+P-1. With the defaults, lane k of port-B row r is port-A word 4r+k.
- R2: In the 9, 18 and 36 bit shapes, each 9-bit lane k of the port word carries data byte k in bits 9k to 9k+7 and that byte's parity bit in bit 9k+8. Parity bits are stored apart from data bits and read back unchanged.
- R3: A word written through a port reads back from either port in the shape of the reading port, as long as the two ports did not write overlapping bits in the same cycle.
- R4: Read-before-write: in the cycle a port writes a word, its read data for that cycle shows the contents from before the write.
- R5: Read data appears one clock edge after the address is sampled when the output register is off, and two edges after when it is on. Defaults: port A off, port B on.
- R6: A port sampled with write enable low changes no stored bit, whatever its write data.
- R7: After reset, every stored bit, both read outputs and the collision flag are zero.
- R8: The collision flag is high in the cycle after both ports write overlapping linear bits on a shared clock. It stays low for a single write and for simultaneous writes to disjoint bits.
- R9: Each port's registers update only on its own clock. While port B's clock is held low, port B's output and storage do not change, and port A keeps working.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each clock domain |
| addr_a | input | addr_w(WIDTH_A) | Port A word address (11 with defaults) |
| wdata_a | input | WIDTH_A | Port A write data |
| we_a | input | 1 | Port A write enable |
| rdata_a | output | WIDTH_A | Port A read data |
| addr_b | input | addr_w(WIDTH_B) | Port B word address (9 with defaults) |
| wdata_b | input | WIDTH_B | Port B write data |
| we_b | input | 1 | Port B write enable |
| rdata_b | output | WIDTH_B | Port B read data |
| collision | output | 1 | Overlapping same-cycle writes seen, registered on clk_a |

## Verification
The assertions take for granted that the collision flag is only meaningful when both ports share one clock. That flag samples port B's write strobe in the port-A domain. The stimulus therefore drives both ports from one clock. Port B's clock is only stopped and restarted while that clock is low, and no cell involved in a collision is ever read back. The write-landing property also assumes that a peer write to the same row shows up as a change on the peer row it watches. The stimulus changes inputs only on the falling edge, so that assumption holds.

// File: rtl/mab_pkg.sv
package mab_pkg;
  localparam int DATA_BITS = 16384;
  localparam int ROW_DATA  = 32;
  localparam int ROW_PAR   = 4;
  localparam int ROW_W     = ROW_DATA + ROW_PAR;
  localparam int ROWS      = DATA_BITS / ROW_DATA;
  localparam int ROW_AW    = $clog2(ROWS);

  function automatic bit has_par(int w);
    return (w % 9) == 0;
  endfunction

  function automatic int data_w(int w);
    return has_par(w) ? (w / 9) * 8 : w;
  endfunction

  function automatic int par_w(int w);
    return has_par(w) ? w / 9 : 0;
  endfunction

  function automatic int addr_w(int w);
    return $clog2(DATA_BITS / data_w(w));
  endfunction

  function automatic bit legal_w(int w);
    return w == 1 || w == 2 || w == 4 || w == 8 || w == 16 || w == 32 ||
           w == 9 || w == 18 || w == 36;
  endfunction
endpackage

// File: rtl/mab_rst_sync.sv
module mab_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      srst_n <= meta_q;
    end
  end
endmodule

// File: rtl/mab_port.sv
// One port: owns one copy of the XOR-split store, reads the peer copy.
module mab_port import mab_pkg::*; #(
  parameter int W       = 9,
  parameter bit OUT_REG = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [addr_w(W)-1:0] addr,
  input  logic [W-1:0]         wdata,
  input  logic                 we,
  output logic [ROW_AW-1:0]    row_o,
  input  logic [ROW_W-1:0]     peer_row_i,
  input  logic [ROW_AW-1:0]    peer_idx_i,
  output logic [ROW_W-1:0]     own_at_peer_o,
  output logic [W-1:0]         rdata
);
  localparam int AW    = addr_w(W);
  localparam int DW    = data_w(W);
  localparam int PW    = par_w(W);
  localparam int SLOTS = ROW_DATA / DW;

  logic [ROW_W-1:0] mem_q [ROWS];
  logic [ROW_W-1:0] own_row, cur_row, own_nxt;
  logic [W-1:0]     cur_word, rd1_q;
  int               slot;

  // address to row and slot within the row
  always_comb begin
    row_o   = ROW_AW'(int'(addr) / SLOTS);
    slot    = int'(addr) % SLOTS;
    own_row = mem_q[row_o];
    cur_row = own_row ^ peer_row_i;
  end

  assign own_at_peer_o = mem_q[peer_idx_i];

  // next-state for the written row and the word read out
  if (PW == 0) begin : g_plain
    always_comb begin
      own_nxt = own_row;
      own_nxt[slot*DW +: DW] = wdata ^ peer_row_i[slot*DW +: DW];
      cur_word = cur_row[slot*DW +: DW];
    end
  end else begin : g_par
    always_comb begin
      own_nxt  = own_row;
      cur_word = '0;
      for (int k = 0; k < PW; k++) begin
        own_nxt[slot*DW + 8*k +: 8] = wdata[9*k +: 8] ^ peer_row_i[slot*DW + 8*k +: 8];
        own_nxt[ROW_DATA + slot*PW + k] = wdata[9*k + 8] ^ peer_row_i[ROW_DATA + slot*PW + k];
        cur_word[9*k +: 8] = cur_row[slot*DW + 8*k +: 8];
        cur_word[9*k + 8]  = cur_row[ROW_DATA + slot*PW + k];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) mem_q[r] <= '0;
      rd1_q <= '0;
    end else begin
      if (we) mem_q[row_o] <= own_nxt;
      rd1_q <= cur_word;
    end
  end

  if (OUT_REG) begin : g_oreg
    logic [W-1:0] rd2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd2_q <= '0;
      else        rd2_q <= rd1_q;
    end
    assign rdata = rd2_q;
  end else begin : g_noreg
    assign rdata = rd1_q;
  end

  // checker state for the write-landing property
  logic          prev_we;
  logic [AW-1:0] prev_addr;
  logic [W-1:0]  prev_wdata;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_we    <= 1'b0;
      prev_addr  <= '0;
      prev_wdata <= '0;
    end else begin
      prev_we    <= we;
      prev_addr  <= addr;
      prev_wdata <= wdata;
    end
  end

  assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_we && !we && addr == prev_addr && $stable(peer_row_i)) |=> rd1_q == $past(prev_wdata));

  assert_read_old_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wdata != cur_word) |=> rd1_q != $past(wdata));

  assert_reset_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> rdata == '0);
endmodule

// File: rtl/mab_dpram.sv
module mab_dpram import mab_pkg::*; #(
  parameter int WIDTH_A   = 9,
  parameter int WIDTH_B   = 36,
  parameter bit OUT_REG_A = 1'b0,
  parameter bit OUT_REG_B = 1'b1
) (
  input  logic                       clk_a,
  input  logic                       clk_b,
  input  logic                       rst_n,
  input  logic [addr_w(WIDTH_A)-1:0] addr_a,
  input  logic [WIDTH_A-1:0]         wdata_a,
  input  logic                       we_a,
  output logic [WIDTH_A-1:0]         rdata_a,
  input  logic [addr_w(WIDTH_B)-1:0] addr_b,
  input  logic [WIDTH_B-1:0]         wdata_b,
  input  logic                       we_b,
  output logic [WIDTH_B-1:0]         rdata_b,
  output logic                       collision
);
  localparam int DWA = data_w(WIDTH_A);
  localparam int DWB = data_w(WIDTH_B);

  if (!legal_w(WIDTH_A) || !legal_w(WIDTH_B)) begin : g_bad_shape
    $error("mab_dpram: unsupported port width");
  end
  if (has_par(WIDTH_A) != has_par(WIDTH_B)) begin : g_bad_par
    $error("mab_dpram: parity shapes must be used on both ports or on neither");
  end

  logic srst_a_n, srst_b_n;
  logic [ROW_AW-1:0] row_a, row_b;
  logic [ROW_W-1:0]  a_at_b, b_at_a;

  mab_rst_sync u_sync_a (.clk(clk_a), .arst_n(rst_n), .srst_n(srst_a_n));
  mab_rst_sync u_sync_b (.clk(clk_b), .arst_n(rst_n), .srst_n(srst_b_n));

  mab_port #(.W(WIDTH_A), .OUT_REG(OUT_REG_A)) u_port_a (
    .clk(clk_a), .rst_n(srst_a_n), .addr(addr_a), .wdata(wdata_a), .we(we_a),
    .row_o(row_a), .peer_row_i(b_at_a), .peer_idx_i(row_b),
    .own_at_peer_o(a_at_b), .rdata(rdata_a));

  mab_port #(.W(WIDTH_B), .OUT_REG(OUT_REG_B)) u_port_b (
    .clk(clk_b), .rst_n(srst_b_n), .addr(addr_b), .wdata(wdata_b), .we(we_b),
    .row_o(row_b), .peer_row_i(a_at_b), .peer_idx_i(row_a),
    .own_at_peer_o(b_at_a), .rdata(rdata_b));

  // overlap of linear data-bit ranges; parity ranges scale with them
  int   lo_a, lo_b;
  logic coll_nxt, coll_q;
  always_comb begin
    lo_a     = int'(addr_a) * DWA;
    lo_b     = int'(addr_b) * DWB;
    coll_nxt = we_a && we_b && (lo_a < lo_b + DWB) && (lo_b < lo_a + DWA);
  end

  always_ff @(posedge clk_a or negedge srst_a_n) begin
    if (!srst_a_n) coll_q <= 1'b0;
    else           coll_q <= coll_nxt;
  end
  assign collision = coll_q;

  assert_coll_needs_writes_R8: assert property (@(posedge clk_a) disable iff (!srst_a_n)
    collision |-> ($past(we_a) && $past(we_b)));
endmodule

// File: tb/mab_dpram_tb.sv
module mab_dpram_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WA = 9, WB = 36, AWA = 11, AWB = 9;

  typedef struct { int due; logic [35:0] val; string req; } item_t;

  logic clk = 1'b0, b_run = 1'b1, rst_n = 1'b0;
  logic clk_b;
  logic [AWA-1:0] addr_a = '0;
  logic [WA-1:0]  wdata_a = '0;
  logic           we_a = 1'b0;
  logic [AWB-1:0] addr_b = '0;
  logic [WB-1:0]  wdata_b = '0;
  logic           we_b = 1'b0;
  logic [WA-1:0]  rdata_a;
  logic [WB-1:0]  rdata_b;
  logic           collision;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;
  item_t qa[$], qb[$], qc[$];
  logic [16383:0] dm = '0;
  logic [2047:0]  pm = '0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign clk_b = clk & b_run;
  always @(posedge clk) cyc <= cyc + 1;

  mab_dpram dut_i (
    .clk_a(clk), .clk_b(clk_b), .rst_n(rst_n),
    .addr_a(addr_a), .wdata_a(wdata_a), .we_a(we_a), .rdata_a(rdata_a),
    .addr_b(addr_b), .wdata_b(wdata_b), .we_b(we_b), .rdata_b(rdata_b),
    .collision(collision));

  // reference model built from R1/R2
  function automatic logic [8:0] mrd_a(int a);
    return {pm[a], dm[a*8 +: 8]};
  endfunction
  function automatic logic [35:0] mrd_b(int r);
    logic [35:0] v;
    for (int k = 0; k < 4; k++) begin
      v[9*k +: 8] = dm[r*32 + 8*k +: 8];
      v[9*k + 8]  = pm[r*4 + k];
    end
    return v;
  endfunction
  task automatic mwr_a(int a, logic [8:0] d);
    dm[a*8 +: 8] = d[7:0];
    pm[a] = d[8];
  endtask
  task automatic mwr_b(int r, logic [35:0] d);
    for (int k = 0; k < 4; k++) begin
      dm[r*32 + 8*k +: 8] = d[9*k +: 8];
      pm[r*4 + k] = d[9*k + 8];
    end
  endtask

  task automatic chk(input logic [35:0] act, input logic [35:0] exp, input string req, input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // driver: one cycle of stimulus, expected results pushed to the scoreboard
  task automatic step(input logic wa, input int aa, input logic [8:0] da,
                      input logic wb, input int ab, input logic [35:0] db, input string req);
    bit hit;
    @(negedge clk);
    we_a = wa; addr_a = AWA'(aa); wdata_a = da;
    we_b = wb; addr_b = AWB'(ab); wdata_b = db;
    hit = wa && wb && (aa / 4 == ab);
    qa.push_back('{cyc + 1, 36'(mrd_a(aa)), req});
    if (b_run) qb.push_back('{cyc + 2, mrd_b(ab), req});
    qc.push_back('{cyc + 1, 36'(hit), "R8"});
    if (!hit) begin
      if (wa) mwr_a(aa, da);
      if (wb && b_run) mwr_b(ab, db);
    end
  endtask

  // monitor: compare due items away from the active edge
  always @(negedge clk) begin
    item_t it;
    while (qa.size() > 0 && qa[0].due <= cyc) begin
      it = qa.pop_front();
      chk(36'(rdata_a), it.val, it.req, "port A read data");
    end
    while (qb.size() > 0 && qb[0].due <= cyc) begin
      it = qb.pop_front();
      chk(rdata_b, it.val, it.req, "port B read data");
    end
    while (qc.size() > 0 && qc[0].due <= cyc) begin
      it = qc.pop_front();
      chk(36'(collision), it.val, it.req, "collision flag");
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [35:0] hold;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(36'(rdata_a), '0, "R7", "port A output after reset");
    chk(rdata_b, '0, "R7", "port B output after reset");
    chk(36'(collision), '0, "R7", "collision after reset");
    step(0, 100, 0, 0, 7, 0, "R7");
    step(0, 2047, 0, 0, 511, 0, "R7");

    for (int k = 0; k < 8; k++) step(1, k, 9'(9'h0A5 + 37*k), 0, 0, 0, "R3");
    for (int k = 0; k < 8; k++) step(0, k, 0, 0, 1, 0, "R3");
    step(0, 0, 0, 0, 0, 0, "R1");
    step(0, 4, 0, 0, 1, 0, "R1");

    step(0, 0, 0, 1, 10, 36'hA5C31E7F6, "R2");
    for (int k = 40; k < 44; k++) step(0, k, 0, 0, 10, 0, "R2");

    step(1, 3, 9'h1C4, 0, 0, 0, "R4");
    step(0, 3, 0, 0, 0, 0, "R3");
    step(0, 0, 0, 1, 10, 36'h0F0F0F0F0, "R4");
    step(0, 41, 0, 0, 10, 0, "R3");

    for (int k = 0; k < 6; k++) step(0, 40 + k, 0, 0, (k % 2 == 1) ? 10 : 0, 0, "R5");

    step(0, 3, 9'h1FF, 0, 10, 36'hFFFFFFFFF, "R6");
    step(0, 3, 0, 0, 10, 0, "R6");

    step(1, 44, 9'h155, 1, 11, 36'h123456789, "R8");
    step(1, 48, 9'h0AA, 1, 13, 36'h1E1E1E1E1, "R8");
    step(1, 60, 9'h101, 0, 15, 0, "R8");
    step(0, 48, 0, 0, 13, 0, "R8");
    step(0, 60, 0, 0, 12, 0, "R8");

    repeat (2) @(negedge clk);
    hold = rdata_b;
    b_run = 1'b0;
    step(1, 50, 9'h033, 1, 5, 36'h777777777, "R9");
    step(0, 50, 0, 1, 6, 36'h555555555, "R9");
    step(0, 3, 0, 1, 5, 36'h333333333, "R9");
    @(negedge clk);
    chk(rdata_b, hold, "R9", "port B output with its clock held");
    we_b = 1'b0;
    b_run = 1'b1;
    step(0, 50, 0, 0, 5, 0, "R9");
    step(0, 20, 0, 0, 6, 0, "R9");
    repeat (4) @(negedge clk);
    report();
  end
endmodule